// File: doc/BRIEF.md
# Local Scan Port Chain Configurator

This block sits behind the backplane test port of a scan bridge and joins up to three local scan chains to it. An 8-bit configuration register is loaded through the bridge's data path while a configuration-select instruction is decoded. Its low three bits pick which local ports take part. On an unpark command, the chosen ports are stitched in series between the backplane TDI and TDO, and their TMS outputs follow the backplane TMS.

The block has two park commands. The first forces every local TMS high, which walks each local TAP to Test-Logic-Reset. The second does the same as part of the bridge's return to its wait-for-address state. A parked port gets a constant high on its TDI and its TDO is left out of the chain. When no port is connected, a single bypass flop stands in for the chain. The configuration register keeps its value through park and unpark. Only Test-Logic-Reset clears it.

Top module: `lsp_chain_cfg`

## Requirements
- R1: After reset, all local TMS and TDI outputs are high, the configuration register reads zero, and bp_tdo is driven by the bypass flop, which is cleared.
- R2: While mode_sel is high, cap_dr loads the configuration register into a shift register. shift_dr then shifts it LSB first from bp_tdi toward bp_tdo. upd_dr copies the shift register into the configuration register one cycle later.
- R3: An unpark command (ir_upd with ir_op = 2'b01) connects exactly the ports whose bit is set in configuration bits [2:0], where bit n selects port n. A connected port's TMS equals bp_tms. Bits [7:3] have no effect.
- R4: Connected ports are chained in ascending port order. When mode_sel is low, the delay from bp_tdi to bp_tdo in tck cycles is the sum of the connected chain lengths. With no port connected, the delay is one cycle through the bypass flop, which loads while shift_dr is high.
- R5: A port that is not connected has its TMS and TDI held high, and its TDO does not affect bp_tdo.
- R6: A park command (ir_op = 2'b10) disconnects every port, so all local TMS outputs read high in the following cycle.
- R7: A return-to-wait command (ir_op = 2'b11) also disconnects every port and drives all local TMS high.
- R8: Park, return-to-wait and unpark leave the configuration register unchanged.
- R9: tlr clears the configuration register and disconnects every port. It takes precedence over any command or update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | Bridge TAP is in Test-Logic-Reset |
| bp_tms | input | 1 | Backplane TMS |
| bp_tdi | input | 1 | Backplane TDI |
| mode_sel | input | 1 | Configuration-select instruction is active |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| ir_upd | input | 1 | Update-IR strobe for the command in ir_op |
| ir_op | input | 2 | 01 unpark, 10 park, 11 return-to-wait, 00 none |
| lsp_tdo | input | NPORT | TDO returned by each local port |
| lsp_tms | output | NPORT | TMS to each local port |
| lsp_tdi | output | NPORT | TDI to each local port |
| bp_tdo | output | 1 | Combined TDO back to the backplane |

## Verification
A Test-Logic-Reset indication and an unpark command can arrive in the same tck cycle. The two conflict, because one connects ports while the other must leave the configuration cleared and everything parked. The bench connects all three ports, then raises tlr together with an unpark strobe at a single edge. It then checks that every local TMS reads high while bp_tms is low, and that a capture of the configuration register shifts back zero.

// File: rtl/lsp_chain_cfg.sv
module lsp_chain_cfg #(
  parameter int NPORT  = 3,
  parameter int MODE_W = 8
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             bp_tms,
  input  logic             bp_tdi,
  input  logic             mode_sel,
  input  logic             cap_dr,
  input  logic             shift_dr,
  input  logic             upd_dr,
  input  logic             ir_upd,
  input  logic [1:0]       ir_op,
  input  logic [NPORT-1:0] lsp_tdo,
  output logic [NPORT-1:0] lsp_tms,
  output logic [NPORT-1:0] lsp_tdi,
  output logic             bp_tdo
);
  localparam logic [1:0] OP_UNPARK = 2'b01;
  localparam logic [1:0] OP_PARK   = 2'b10;
  localparam logic [1:0] OP_WAIT   = 2'b11;

  logic [MODE_W-1:0] mode_q, mode_sr;
  logic [NPORT-1:0]  conn_q;
  logic              byp_q;
  logic [NPORT:0]    link;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mode_sr <= '0;
      conn_q  <= '0;
      byp_q   <= 1'b0;
    end else if (tlr) begin
      mode_q  <= '0;
      mode_sr <= '0;
      conn_q  <= '0;
      byp_q   <= 1'b0;
    end else begin
      if (shift_dr) byp_q <= bp_tdi;
      if (mode_sel) begin
        if (cap_dr)        mode_sr <= mode_q;
        else if (shift_dr) mode_sr <= {bp_tdi, mode_sr[MODE_W-1:1]};
        if (upd_dr)        mode_q  <= mode_sr;
      end
      if (ir_upd) begin
        case (ir_op)
          OP_UNPARK:        conn_q <= mode_q[NPORT-1:0];
          OP_PARK, OP_WAIT: conn_q <= '0;
          default:          ;
        endcase
      end
    end
  end

  assign link[0] = bp_tdi;

  for (genvar n = 0; n < NPORT; n++) begin : g_port
    assign lsp_tms[n]  = conn_q[n] ? bp_tms : 1'b1;
    assign lsp_tdi[n]  = conn_q[n] ? link[n] : 1'b1;
    assign link[n+1]   = conn_q[n] ? lsp_tdo[n] : link[n];
  end

  assign bp_tdo = mode_sel ? mode_sr[0] : (|conn_q ? link[NPORT] : byp_q);
endmodule

module lsp_chain_cfg_chk #(
  parameter int NPORT  = 3,
  parameter int MODE_W = 8
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tlr,
  input logic              mode_sel,
  input logic              upd_dr,
  input logic              ir_upd,
  input logic [1:0]        ir_op,
  input logic [NPORT-1:0]  lsp_tms,
  input logic [MODE_W-1:0] mode_q,
  input logic [MODE_W-1:0] mode_sr,
  input logic [NPORT-1:0]  conn_q
);
  // R2
  mode_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    mode_sel && upd_dr && !tlr |=> mode_q == $past(mode_sr));
  // R3
  unpark_conn_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ir_upd && ir_op == 2'b01 && !tlr |=> conn_q == $past(mode_q[NPORT-1:0]));
  // R6
  park_tms_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ir_upd && ir_op == 2'b10 |=> &lsp_tms);
  // R7
  wait_tms_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ir_upd && ir_op == 2'b11 |=> &lsp_tms);
  // R8
  mode_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tlr && !(mode_sel && upd_dr) |=> $stable(mode_q));
  // R9
  tlr_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> mode_q == '0 && conn_q == '0 && &lsp_tms);
endmodule

bind lsp_chain_cfg lsp_chain_cfg_chk #(.NPORT(NPORT), .MODE_W(MODE_W)) chk_i (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .mode_sel(mode_sel), .upd_dr(upd_dr),
  .ir_upd(ir_upd), .ir_op(ir_op), .lsp_tms(lsp_tms), .mode_q(mode_q),
  .mode_sr(mode_sr), .conn_q(conn_q)
);

// File: tb/lsp_chain_cfg_tb.sv
`timescale 1ns/1ps
module lsp_chain_cfg_tb_top;
  logic tck = 1'b0, rst_n = 1'b0, tlr = 1'b0, bp_tms = 1'b1, bp_tdi = 1'b0;
  logic mode_sel = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, ir_upd = 1'b0;
  logic [1:0] ir_op = 2'b00;
  logic [2:0] lsp_tdo, lsp_tms, lsp_tdi;
  logic bp_tdo;
  int checks = 0, fails = 0;

  logic [2:0] sr0 = '0;
  logic [4:0] sr1 = '0;
  logic [6:0] sr2 = '0;
  localparam int LEN [3] = '{3, 5, 7};
  localparam logic [63:0] PAT = 64'hA5C3_96F0_1E78_D24B;

  always #2 tck = ~tck;

  always_ff @(posedge tck) begin
    sr0 <= {lsp_tdi[0], sr0[2:1]};
    sr1 <= {lsp_tdi[1], sr1[4:1]};
    sr2 <= {lsp_tdi[2], sr2[6:1]};
  end
  assign lsp_tdo = {sr2[0], sr1[0], sr0[0]};

  lsp_chain_cfg dut_i (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .bp_tms(bp_tms), .bp_tdi(bp_tdi),
    .mode_sel(mode_sel), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
    .ir_upd(ir_upd), .ir_op(ir_op), .lsp_tdo(lsp_tdo), .lsp_tms(lsp_tms),
    .lsp_tdi(lsp_tdi), .bp_tdo(bp_tdo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    @(negedge tck); mode_sel = 1'b1; shift_dr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bp_tdi = v[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; upd_dr = 1'b1;
    @(negedge tck); upd_dr = 1'b0; mode_sel = 1'b0;
  endtask

  task automatic read_mode(output logic [7:0] v);
    @(negedge tck); mode_sel = 1'b1; cap_dr = 1'b1;
    @(negedge tck); cap_dr = 1'b0; shift_dr = 1'b1; bp_tdi = 1'b0;
    for (int i = 0; i < 8; i++) begin
      v[i] = bp_tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0; mode_sel = 1'b0;
  endtask

  task automatic command(input logic [1:0] op);
    @(negedge tck); ir_upd = 1'b1; ir_op = op;
    @(negedge tck); ir_upd = 1'b0; ir_op = 2'b00;
  endtask

  task automatic measure(input int exp_len, input string req);
    int bad = 0;
    @(negedge tck); shift_dr = 1'b1; bp_tdi = 1'b0;
    for (int i = 0; i < 20; i++) @(negedge tck);
    for (int i = 0; i < 48; i++) begin
      if (i >= exp_len && bp_tdo !== PAT[i-exp_len]) bad++;
      bp_tdi = PAT[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; bp_tdi = 1'b0;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    logic [7:0] m;
    chk(lsp_tms === 3'b111 && lsp_tdi === 3'b111, "R1 outputs high", {lsp_tms, lsp_tdi}, 6'h3f);
    chk(bp_tdo === 1'b0, "R1 bypass cleared", bp_tdo, 0);
    read_mode(m);
    chk(m === 8'h00, "R1 mode zero", m, 0);
  endtask

  task automatic t_mode_path;
    logic [7:0] m;
    write_mode(8'hC6);
    read_mode(m);
    chk(m === 8'hC6, "R2 mode write/readback", m, 8'hC6);
    write_mode(8'h39);
    read_mode(m);
    chk(m === 8'h39, "R2 second pattern", m, 8'h39);
  endtask

  task automatic t_lengths;
    for (int md = 0; md < 8; md++) begin
      int len = 0;
      for (int n = 0; n < 3; n++) if (md[n]) len += LEN[n];
      if (len == 0) len = 1;
      write_mode({5'b10110, md[2:0]});
      command(2'b01);
      bp_tms = 1'b0;
      @(negedge tck);
      // R3 connected ports follow bp_tms, R5 others held high
      chk(lsp_tms === ~md[2:0], "R3 tms routing", lsp_tms, ~md[2:0]);
      for (int n = 0; n < 3; n++)
        if (!md[n]) chk(lsp_tdi[n] === 1'b1, "R5 parked tdi high", lsp_tdi[n], 1);
      measure(len, md == 0 ? "R4 bypass length" : "R4 series length");
      bp_tms = 1'b1;
    end
  endtask

  task automatic t_park;
    write_mode(8'h07); command(2'b01); bp_tms = 1'b0;
    command(2'b10);
    chk(lsp_tms === 3'b111, "R6 park forces tms", lsp_tms, 3'b111);
    measure(1, "R5 parked ports excluded");
    bp_tms = 1'b1;
  endtask

  task automatic t_wait;
    command(2'b01); bp_tms = 1'b0;
    @(negedge tck);
    chk(lsp_tms === 3'b000, "R7 precondition connected", lsp_tms, 0);
    command(2'b11);
    chk(lsp_tms === 3'b111 && lsp_tdi === 3'b111, "R7 wait parks", {lsp_tms, lsp_tdi}, 6'h3f);
    bp_tms = 1'b1;
  endtask

  task automatic t_retain;
    logic [7:0] m;
    write_mode(8'hA5);
    command(2'b10); command(2'b11); command(2'b01);
    bp_tms = 1'b0;
    @(negedge tck);
    chk(lsp_tms === 3'b010, "R8 mode kept for unpark", lsp_tms, 3'b010);
    read_mode(m);
    chk(m === 8'hA5, "R8 mode retained", m, 8'hA5);
    bp_tms = 1'b1;
    command(2'b10);
  endtask

  task automatic t_collide;
    logic [7:0] m;
    write_mode(8'h07); command(2'b01);
    @(negedge tck); tlr = 1'b1; ir_upd = 1'b1; ir_op = 2'b01; bp_tms = 1'b0;
    @(negedge tck); tlr = 1'b0; ir_upd = 1'b0; ir_op = 2'b00;
    chk(lsp_tms === 3'b111, "R9 tlr beats unpark", lsp_tms, 3'b111);
    read_mode(m);
    chk(m === 8'h00, "R9 mode cleared", m, 0);
    bp_tms = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);
    t_reset();
    t_mode_path();
    t_lengths();
    t_park();
    t_wait();
    t_retain();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule